// File: doc/BRIEF.md
# Exception Entry Sequencer

This block starts exception handling in a processor core that runs in two instruction states. In the full state instructions are 4 bytes wide. In the compact state they are 2 bytes wide. Three request lines feed the block: one for the external interrupt, one for the software interrupt and one for the undefined instruction. Each request is a one-cycle pulse. The block also receives the current program counter, the current status word and the current instruction state.

In each cycle the block accepts at most one request. It selects the winner by a fixed priority. An interrupt request is dropped while the status word masks interrupts.

For the accepted request the block registers a set of results:
- the target mode and a write strobe for the banked register file;
- the return (link) address;
- the handler address;
- the new status word, with the mode replaced, the compact state cleared and interrupts masked;
- the old status word, for the saved-status register of the new mode;
- a one-cycle flush that tells the fetch unit to refill from the handler address.

The results appear on the clock edge that samples the request.

Top module: `exc_entry_seq`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), all outputs are zero. This includes `ent_flush` and `ent_mode_we`.
- R2: When `req_irq` is the only request and bit 7 of `cur_psr` (the interrupt mask) is 1, the request is dropped. No flush or mode write follows.
- R3: For an accepted interrupt, `ent_link` equals `cur_pc` minus the instruction width plus 4, modulo 2^AW.
- R4: For an accepted software interrupt or undefined instruction, `ent_link` equals `cur_pc` minus the instruction width, modulo 2^AW.
- R5: The instruction width is 2 when `cur_compact` is 1 and 4 when it is 0.
- R6: `ent_mode` takes one of these values:
  - 5'h12 for an interrupt;
  - 5'h13 for a software interrupt;
  - 5'h1B for an undefined instruction.
- R7: `ent_pc` takes one of these values:
  - 0x18 for an interrupt;
  - 0x08 for a software interrupt;
  - 0x04 for an undefined instruction.
- R8: `ent_psr` equals the pre-entry `cur_psr` with these changes, and all other bits unchanged:
  - bits [4:0] replaced by the new mode;
  - bit 5 (compact state) cleared;
  - bit 7 (interrupt mask) set.
- R9: `ent_spsr` equals the `cur_psr` value that was sampled with the accepted request.
- R10: When several requests arrive together, the undefined instruction wins over the software interrupt, which wins over the interrupt. The losing requests are discarded, and only one entry happens per cycle.
- R11: `ent_flush` and `ent_mode_we` are high for exactly the one cycle after the edge that accepted a request. They are low in every other cycle. The data outputs hold their last values between entries.
- R12: The interrupt mask has no effect on software-interrupt or undefined-instruction requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_irq | input | 1 | External interrupt request pulse |
| req_swi | input | 1 | Software interrupt request pulse |
| req_und | input | 1 | Undefined instruction request pulse |
| cur_pc | input | AW | Current program counter |
| cur_psr | input | PW | Current status word. Bits [4:0] are the mode, bit 5 is the compact state, bit 7 is the interrupt mask |
| cur_compact | input | 1 | Current instruction state, 1 for the 2-byte state |
| ent_flush | output | 1 | One-cycle pipeline flush |
| ent_mode_we | output | 1 | One-cycle mode-change strobe to the banked register file |
| ent_mode | output | 5 | Target mode code |
| ent_link | output | AW | Return address for the link register |
| ent_pc | output | AW | Handler address |
| ent_psr | output | PW | New status word |
| ent_spsr | output | PW | Value for the saved-status register |

## Verification
Every result is registered one edge after the request. A wrong priority, mask or width decision therefore shows up in the very next cycle. It appears as a wrong `ent_mode`, a wrong handler address, or a link value that is off by 2 or 4. A wrong acceptance decision shows up in the same cycle as a missing or extra `ent_flush` pulse. Because the data outputs hold their values between entries, a stray load is also visible later: outputs that change in a cycle without a flush expose it.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int MODE_W = 5;

  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

  // grant vector index, lower index wins
  localparam int G_UND = 0;
  localparam int G_SWI = 1;
  localparam int G_IRQ = 2;
  localparam int N_SRC = 3;
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end
endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
  import exc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PW        = 32,
  parameter int MASK_BIT  = 7,
  parameter int STATE_BIT = 5,
  parameter logic [AW-1:0] VEC_UND = 'h04,
  parameter logic [AW-1:0] VEC_SWI = 'h08,
  parameter logic [AW-1:0] VEC_IRQ = 'h18
) (
  input  logic [N_SRC-1:0]  grant,
  input  logic [AW-1:0]     pc,
  input  logic              compact,
  input  logic [PW-1:0]     psr,
  output logic [MODE_W-1:0] mode,
  output logic [AW-1:0]     link,
  output logic [AW-1:0]     vec,
  output logic [PW-1:0]     psr_new
);
  localparam logic [AW-1:0] W_FULL = AW'(4);
  localparam logic [AW-1:0] W_CMP  = AW'(2);

  logic [AW-1:0] width;
  logic [AW-1:0] back;

  assign width = compact ? W_CMP : W_FULL;
  assign back  = pc - width;

  always_comb begin
    mode = MODE_IRQ;
    vec  = VEC_IRQ;
    link = back + W_FULL;
    if (grant[G_UND]) begin
      mode = MODE_UND;
      vec  = VEC_UND;
      link = back;
    end else if (grant[G_SWI]) begin
      mode = MODE_SVC;
      vec  = VEC_SWI;
      link = back;
    end
  end

  always_comb begin
    psr_new                = psr;
    psr_new[MODE_W-1:0]    = mode;
    psr_new[STATE_BIT]     = 1'b0;
    psr_new[MASK_BIT]      = 1'b1;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PW        = 32,
  parameter int MASK_BIT  = 7,
  parameter int STATE_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_irq,
  input  logic              req_swi,
  input  logic              req_und,
  input  logic [AW-1:0]     cur_pc,
  input  logic [PW-1:0]     cur_psr,
  input  logic              cur_compact,
  output logic              ent_flush,
  output logic              ent_mode_we,
  output logic [MODE_W-1:0] ent_mode,
  output logic [AW-1:0]     ent_link,
  output logic [AW-1:0]     ent_pc,
  output logic [PW-1:0]     ent_psr,
  output logic [PW-1:0]     ent_spsr
);
  logic [N_SRC-1:0]  req_vec;
  logic [N_SRC-1:0]  grant;
  logic [MODE_W-1:0] nx_mode;
  logic [AW-1:0]     nx_link;
  logic [AW-1:0]     nx_vec;
  logic [PW-1:0]     nx_psr;
  logic              take;

  always_comb begin
    req_vec        = '0;
    req_vec[G_UND] = req_und;
    req_vec[G_SWI] = req_swi;
    req_vec[G_IRQ] = req_irq & ~cur_psr[MASK_BIT];
  end

  exc_prio_sel #(.N(N_SRC)) u_sel (
    .req   (req_vec),
    .grant (grant)
  );

  exc_target_calc #(
    .AW(AW), .PW(PW), .MASK_BIT(MASK_BIT), .STATE_BIT(STATE_BIT)
  ) u_calc (
    .grant   (grant),
    .pc      (cur_pc),
    .compact (cur_compact),
    .psr     (cur_psr),
    .mode    (nx_mode),
    .link    (nx_link),
    .vec     (nx_vec),
    .psr_new (nx_psr)
  );

  assign take = |grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_flush   <= 1'b0;
      ent_mode_we <= 1'b0;
      ent_mode    <= '0;
      ent_link    <= '0;
      ent_pc      <= '0;
      ent_psr     <= '0;
      ent_spsr    <= '0;
    end else begin
      ent_flush   <= take;
      ent_mode_we <= take;
      if (take) begin
        ent_mode <= nx_mode;
        ent_link <= nx_link;
        ent_pc   <= nx_vec;
        ent_psr  <= nx_psr;
        ent_spsr <= cur_psr;
      end
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PW        = 32,
  parameter int MASK_BIT  = 7,
  parameter int STATE_BIT = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_irq,
  input logic              req_swi,
  input logic              req_und,
  input logic [AW-1:0]     cur_pc,
  input logic [PW-1:0]     cur_psr,
  input logic              cur_compact,
  input logic              ent_flush,
  input logic              ent_mode_we,
  input logic [MODE_W-1:0] ent_mode,
  input logic [AW-1:0]     ent_link,
  input logic [AW-1:0]     ent_pc,
  input logic [PW-1:0]     ent_psr,
  input logic [PW-1:0]     ent_spsr
);
  logic hit;
  assign hit = req_und | req_swi | (req_irq & ~cur_psr[MASK_BIT]);

  p_flush_follows_r11: assert property (@(posedge clk) disable iff (rst)
    hit |=> (ent_flush && ent_mode_we));

  p_no_stray_flush_r11: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (!ent_flush && !ent_mode_we));

  p_masked_irq_r2: assert property (@(posedge clk) disable iff (rst)
    (req_irq && cur_psr[MASK_BIT] && !req_swi && !req_und) |=> !ent_flush);

  p_und_first_r10: assert property (@(posedge clk) disable iff (rst)
    req_und |=> (ent_mode == MODE_UND && ent_pc == AW'(4)));

  p_swi_mode_r6: assert property (@(posedge clk) disable iff (rst)
    (req_swi && !req_und) |=> (ent_mode == MODE_SVC && ent_pc == AW'(8)));

  p_irq_link_r3: assert property (@(posedge clk) disable iff (rst)
    (req_irq && !cur_psr[MASK_BIT] && !req_swi && !req_und) |=>
      (ent_mode == MODE_IRQ && ent_pc == AW'(24) &&
       ent_link == $past(cur_pc) - ($past(cur_compact) ? AW'(2) : AW'(4)) + AW'(4)));

  p_psr_fields_r8: assert property (@(posedge clk) disable iff (rst)
    ent_flush |-> (ent_psr[MASK_BIT] && !ent_psr[STATE_BIT] &&
                   ent_psr[MODE_W-1:0] == ent_mode));

  p_saved_psr_r9: assert property (@(posedge clk) disable iff (rst)
    hit |=> (ent_spsr == $past(cur_psr)));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .AW(AW), .PW(PW), .MASK_BIT(MASK_BIT), .STATE_BIT(STATE_BIT)
) u_chk (.*);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int PW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_irq, req_swi, req_und, cur_compact;
  logic [AW-1:0] cur_pc;
  logic [PW-1:0] cur_psr;
  logic          ent_flush, ent_mode_we;
  logic [4:0]    ent_mode;
  logic [AW-1:0] ent_link, ent_pc;
  logic [PW-1:0] ent_psr, ent_spsr;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  // expected state, held between entries
  logic          e_flush;
  logic [4:0]    e_mode;
  logic [AW-1:0] e_link, e_pc;
  logic [PW-1:0] e_psr, e_spsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq #(.AW(AW), .PW(PW)) u_dut (
    .clk(clk), .rst(rst), .req_irq(req_irq), .req_swi(req_swi),
    .req_und(req_und), .cur_pc(cur_pc), .cur_psr(cur_psr),
    .cur_compact(cur_compact), .ent_flush(ent_flush),
    .ent_mode_we(ent_mode_we), .ent_mode(ent_mode), .ent_link(ent_link),
    .ent_pc(ent_pc), .ent_psr(ent_psr), .ent_spsr(ent_spsr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model of one accepted request, from the requirements
  task automatic model(input logic i, input logic s, input logic u,
                       input logic [AW-1:0] pc, input logic [PW-1:0] psr,
                       input logic cmp);
    logic [AW-1:0] w;
    logic          irq_ok;
    w      = cmp ? 2 : 4;                  // R5
    irq_ok = i && !psr[7];                 // R2 R12
    e_flush = u || s || irq_ok;            // R11
    if (e_flush) begin
      if (u) begin                         // R10 priority
        e_mode = 5'h1B; e_pc = 'h04; e_link = pc - w;   // R4 R6 R7
      end else if (s) begin
        e_mode = 5'h13; e_pc = 'h08; e_link = pc - w;   // R4
      end else begin
        e_mode = 5'h12; e_pc = 'h18; e_link = pc - w + 4; // R3
      end
      e_psr = psr;                         // R8
      e_psr[4:0] = e_mode;
      e_psr[5]   = 1'b0;
      e_psr[7]   = 1'b1;
      e_spsr = psr;                        // R9
    end
  endtask

  task automatic step(input logic i, input logic s, input logic u,
                      input logic [AW-1:0] pc, input logic [PW-1:0] psr,
                      input logic cmp, input string tag);
    req_irq = i; req_swi = s; req_und = u;
    cur_pc = pc; cur_psr = psr; cur_compact = cmp;
    model(i, s, u, pc, psr, cmp);
    @(negedge clk);
    chk({tag, " R11 flush"}, 64'(ent_flush), 64'(e_flush));
    chk({tag, " R11 mode_we"}, 64'(ent_mode_we), 64'(e_flush));
    chk({tag, " R6 mode"}, 64'(ent_mode), 64'(e_mode));
    chk({tag, " R7 vector"}, 64'(ent_pc), 64'(e_pc));
    chk({tag, " R3 R4 link"}, 64'(ent_link), 64'(e_link));
    chk({tag, " R8 psr"}, 64'(ent_psr), 64'(e_psr));
    chk({tag, " R9 spsr"}, 64'(ent_spsr), 64'(e_spsr));
    req_irq = 0; req_swi = 0; req_und = 0;
  endtask

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1234);
    rst = 1'b1; req_irq = 0; req_swi = 0; req_und = 0;
    cur_pc = '0; cur_psr = '0; cur_compact = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flush", 64'(ent_flush), 0);
    chk("R1 mode_we", 64'(ent_mode_we), 0);
    chk("R1 mode", 64'(ent_mode), 0);
    chk("R1 link", 64'(ent_link), 0);
    chk("R1 pc", 64'(ent_pc), 0);
    chk("R1 psr", 64'(ent_psr), 0);
    chk("R1 spsr", 64'(ent_spsr), 0);
    rst = 1'b0;
    e_mode = '0; e_link = '0; e_pc = '0; e_psr = '0; e_spsr = '0;

    // directed corner cases
    step(1, 0, 0, 32'h0000_1000, 32'h0000_001F, 0, "irq full R3 R5");
    step(1, 0, 0, 32'h0000_2002, 32'h0000_003F, 1, "irq compact R3 R5");
    step(1, 0, 0, 32'h0000_3000, 32'h0000_009F, 0, "irq masked R2");
    step(0, 1, 0, 32'h0000_4000, 32'hF000_00BF, 1, "swi masked R12 R4");
    step(0, 0, 1, 32'h0000_0000, 32'h0000_00BF, 1, "und wrap R12 R4");
    step(1, 1, 1, 32'h0000_5000, 32'h0000_0010, 0, "all three R10");
    step(1, 1, 0, 32'h0000_6000, 32'h0000_0010, 0, "swi over irq R10");
    step(0, 0, 0, 32'h0000_7000, 32'h0000_0010, 0, "idle hold R11");
    step(0, 0, 0, 32'h0000_0000, 32'h0000_0000, 0, "idle hold2 R11");

    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r[0] | r[3], r[1] & (n[1] ^ r[3]), r[2] & r[1] & n[0],
           $urandom & 32'hFFFF_FFFE, $urandom, 1'($urandom), "random");
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule